// File: doc/BRIEF.md
# Supervisor Reset Generator with Watchdog

This block drives the system reset line of a chip from a set of supervisory timers. Reset is held on after power-on. It is also held while a manual reset request or a low-voltage flag is active. In each of these cases it stays on for a programmable hold time after the cause has gone away. Two configuration bits pick the hold time from four fixed options.

A second timer watches software. If no service strobe arrives within the period picked by two more configuration bits, the timer forces a full reset cycle. One of the four period encodings turns the watchdog off.

All timing counts a free-running millisecond tick input. The clock can therefore run at any rate. Three one-cycle strobes report which event started a reset, so that logic elsewhere can record the reason. The analog comparators and the nonvolatile storage of the configuration bits sit outside this block. The usual configuration is 200 ms hold with the watchdog off (encodings 01 and 11).

Top module: `sup_reset_ctrl`

## Requirements
- R1: While `rst_n` is low, `sys_rst` is 1 and all three cause strobes are 0.
- R2: After the last reset cause clears, `sys_rst` falls on the Nth clock edge that samples `ms_tick` high. N is 50, 200, 400 or 800 for `hold_sel` values 00, 01, 10 and 11.
- R3: While `mr_req` or `lv_flag` is 1, `sys_rst` is 1 from the next edge on, and the hold count restarts from zero.
- R4: The watchdog period is 1400 ticks for `wd_sel` 00, 200 ticks for 01 and 25 ticks for 10.
- R5: With `sys_rst` low and no kick, the watchdog expires on the period-th ticked edge. At that edge `sys_rst` rises and `wd_cause` is 1 for one cycle. After an expiry, reset is held for the full R2 delay.
- R6: An edge that samples `wd_kick` high clears the watchdog count. The next expiry comes one full period of ticks after that edge.
- R7: With `wd_sel` = 11 the watchdog never expires.
- R8: The watchdog count is held at zero while `sys_rst` is 1. The first expiry after a release therefore comes one full period after the release.
- R9: `mr_cause` and `lv_cause` are each 1 for exactly one cycle. That cycle is the edge that first samples the request high. A request held high does not pulse again.
- R10: An edge with `ms_tick` low advances neither the hold count nor the watchdog count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| ms_tick | input | 1 | One-cycle millisecond time base |
| wd_kick | input | 1 | Watchdog service strobe |
| mr_req | input | 1 | Manual reset request, active high |
| lv_flag | input | 1 | Low-voltage indication, active high |
| hold_sel | input | 2 | Reset hold time select |
| wd_sel | input | 2 | Watchdog period select, 11 = off |
| sys_rst | output | 1 | System reset, active high |
| wd_cause | output | 1 | Strobe: reset started by watchdog expiry |
| mr_cause | output | 1 | Strobe: reset started by manual request |
| lv_cause | output | 1 | Strobe: reset started by low voltage |

## Verification
The assertions check the following on every cycle:
- an active request forces reset on the next cycle;
- a watchdog strobe only appears with reset asserted;
- reset only releases on a ticked edge;
- the watchdog count is cleared under reset, after a kick, and never expires while disabled;
- the request strobes last one cycle.

Only the bench scenarios can show the exact tick counts. These are the hold delay for each `hold_sel` value, the watchdog period for each `wd_sel` value measured from a release and from a kick, and the frozen timers when ticks stop.

// File: rtl/sup_pkg.sv
package sup_pkg;

  // Tick counts of the selectable options.
  localparam int HOLD_T0 = 50;
  localparam int HOLD_T1 = 200;
  localparam int HOLD_T2 = 400;
  localparam int HOLD_T3 = 800;
  localparam int WD_T0   = 1400;
  localparam int WD_T1   = 200;
  localparam int WD_T2   = 25;

  localparam int MAX_T   = (WD_T0 > HOLD_T3) ? WD_T0 : HOLD_T3;
  localparam int CNT_W   = $clog2(MAX_T + 1);
  localparam int NUM_REQ = 2;   // level-type reset requests: manual, low voltage

  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [1:0]       sel_t;

  function automatic cnt_t hold_ticks(input sel_t s);
    case (s)
      2'b00:   return cnt_t'(HOLD_T0);
      2'b01:   return cnt_t'(HOLD_T1);
      2'b10:   return cnt_t'(HOLD_T2);
      default: return cnt_t'(HOLD_T3);
    endcase
  endfunction

  function automatic cnt_t wd_ticks(input sel_t s);
    case (s)
      2'b00:   return cnt_t'(WD_T0);
      2'b01:   return cnt_t'(WD_T1);
      2'b10:   return cnt_t'(WD_T2);
      default: return '0;
    endcase
  endfunction

  function automatic logic wd_enabled(input sel_t s);
    return s != 2'b11;
  endfunction

  // True when the count sits on the last tick of a window of length lim.
  function automatic logic at_limit(input cnt_t cnt, input cnt_t lim);
    return (lim != '0) && (cnt >= lim - cnt_t'(1));
  endfunction

endpackage

// File: rtl/sup_hold_timer.sv
module sup_hold_timer
  import sup_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic fault,
  input  logic wd_expire,
  input  sel_t hold_sel,
  output logic sys_rst
);

  cnt_t hold_cnt;
  cnt_t hold_lim;
  logic restart;
  logic hold_done;

  assign hold_lim  = hold_ticks(hold_sel);
  assign restart   = fault | wd_expire;
  assign hold_done = sys_rst & ms_tick & at_limit(hold_cnt, hold_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_rst  <= 1'b1;
      hold_cnt <= '0;
    end else if (restart) begin
      sys_rst  <= 1'b1;
      hold_cnt <= '0;
    end else if (hold_done) begin
      sys_rst  <= 1'b0;
      hold_cnt <= '0;
    end else if (sys_rst && ms_tick) begin
      hold_cnt <= hold_cnt + cnt_t'(1);
    end
  end

  // R3: an active request forces reset on the following edge.
  p_fault_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> sys_rst);

  // R10: release only happens on a ticked edge.
  p_release_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst) |-> $past(ms_tick));

  // R5: a watchdog expiry always restarts the reset.
  p_expire_resets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |=> sys_rst);

endmodule

// File: rtl/sup_watchdog.sv
module sup_watchdog
  import sup_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic wd_kick,
  input  logic sys_rst,
  input  sel_t wd_sel,
  output logic wd_expire
);

  cnt_t wd_cnt;
  cnt_t wd_lim;
  logic wd_on;
  logic wd_clear;

  assign wd_lim    = wd_ticks(wd_sel);
  assign wd_on     = wd_enabled(wd_sel);
  assign wd_clear  = sys_rst | wd_kick | ~wd_on;
  assign wd_expire = ~wd_clear & ms_tick & at_limit(wd_cnt, wd_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_cnt <= '0;
    end else if (wd_clear || wd_expire) begin
      wd_cnt <= '0;
    end else if (ms_tick) begin
      wd_cnt <= wd_cnt + cnt_t'(1);
    end
  end

  // R8: the count is held cleared while reset is asserted.
  p_clear_in_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |=> (wd_cnt == '0));

  // R7: a disabled watchdog never expires.
  p_off_no_expire_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_sel == 2'b11) |-> !wd_expire);

  // R6: a kick leaves no expiry on the next edge.
  p_kick_restarts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wd_kick |=> !wd_expire);

endmodule

// File: rtl/sup_cause_gen.sv
module sup_cause_gen
  import sup_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] req,
  input  logic               wd_expire,
  output logic [NUM_REQ-1:0] req_cause,
  output logic               wd_cause
);

  logic [NUM_REQ-1:0] req_q;

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_edge
    logic rise;
    assign rise = req[i] & ~req_q[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        req_q[i]     <= 1'b0;
        req_cause[i] <= 1'b0;
      end else begin
        req_q[i]     <= req[i];
        req_cause[i] <= rise;
      end
    end

    // R9: each request strobe is a single cycle wide.
    p_req_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_cause[i] |=> !req_cause[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wd_cause <= 1'b0;
    else        wd_cause <= wd_expire;
  end

endmodule

// File: rtl/sup_reset_ctrl.sv
module sup_reset_ctrl
  import sup_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic       wd_kick,
  input  logic       mr_req,
  input  logic       lv_flag,
  input  logic [1:0] hold_sel,
  input  logic [1:0] wd_sel,
  output logic       sys_rst,
  output logic       wd_cause,
  output logic       mr_cause,
  output logic       lv_cause
);

  logic               wd_expire;
  logic               fault;
  logic [NUM_REQ-1:0] req_vec;
  logic [NUM_REQ-1:0] req_cause;

  assign req_vec  = {lv_flag, mr_req};
  assign fault    = |req_vec;
  assign mr_cause = req_cause[0];
  assign lv_cause = req_cause[1];

  sup_hold_timer u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .ms_tick   (ms_tick),
    .fault     (fault),
    .wd_expire (wd_expire),
    .hold_sel  (hold_sel),
    .sys_rst   (sys_rst)
  );

  sup_watchdog u_wd (
    .clk       (clk),
    .rst_n     (rst_n),
    .ms_tick   (ms_tick),
    .wd_kick   (wd_kick),
    .sys_rst   (sys_rst),
    .wd_sel    (wd_sel),
    .wd_expire (wd_expire)
  );

  sup_cause_gen u_cause (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req_vec),
    .wd_expire (wd_expire),
    .req_cause (req_cause),
    .wd_cause  (wd_cause)
  );

  // R5: the watchdog strobe coincides with an asserted reset.
  p_wd_cause_in_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wd_cause |-> sys_rst);

  // R9: a manual strobe comes with reset asserted.
  p_mr_cause_in_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mr_cause |-> sys_rst);

  // R1: directly after power-on reset, no strobe is pending.
  p_quiet_after_por_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !wd_cause && !mr_cause && !lv_cause);

endmodule

// File: tb/sim_sup_reset_ctrl.sv
module sim_sup_reset_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ms_tick = 1'b1;
  logic       wd_kick = 1'b0;
  logic       mr_req = 1'b0;
  logic       lv_flag = 1'b0;
  logic [1:0] hold_sel = 2'b01;
  logic [1:0] wd_sel = 2'b11;
  logic       sys_rst, wd_cause, mr_cause, lv_cause;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;   // 250 MHz

  sup_reset_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .wd_kick(wd_kick),
    .mr_req(mr_req), .lv_flag(lv_flag), .hold_sel(hold_sel), .wd_sel(wd_sel),
    .sys_rst(sys_rst), .wd_cause(wd_cause), .mr_cause(mr_cause),
    .lv_cause(lv_cause)
  );

  function automatic int exp_hold(input logic [1:0] s);
    int t [4] = '{50, 200, 400, 800};
    return t[s];
  endfunction

  function automatic int exp_period(input logic [1:0] s);
    if (s == 2'b10) return 25;
    if (s == 2'b01) return 200;
    return 1400;
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wait_rst(input logic want, input int limit, output int n);
    n = 0;
    do begin cyc(1); n++; end while (sys_rst !== want && n < limit);
  endtask

  // R1, R2: power-on, then release after the hold delay
  task automatic t_por(input logic [1:0] hs, input logic [1:0] ws);
    int n;
    rst_n = 1'b0; hold_sel = hs; wd_sel = ws; ms_tick = 1'b1;
    cyc(3);
    check(sys_rst === 1'b1, "R1", sys_rst, 1);
    check({wd_cause, mr_cause, lv_cause} === 3'b000, "R1",
          {wd_cause, mr_cause, lv_cause}, 0);
    rst_n = 1'b1;
    wait_rst(1'b0, 2000, n);
    check(n == exp_hold(hs), "R2", n, exp_hold(hs));
  endtask

  // R3, R9, R2: level request holds reset, then the delay runs
  task automatic t_fault(input logic use_lv, input logic [1:0] hs);
    int n;
    hold_sel = hs;
    if (use_lv) lv_flag = 1'b1; else mr_req = 1'b1;
    cyc(1);
    check(sys_rst === 1'b1, "R3", sys_rst, 1);
    check(mr_cause === !use_lv, "R9", mr_cause, !use_lv);
    check(lv_cause === use_lv, "R9", lv_cause, use_lv);
    cyc(1);
    check({mr_cause, lv_cause} === 2'b00, "R9", {mr_cause, lv_cause}, 0);
    cyc(40);
    check(sys_rst === 1'b1, "R3", sys_rst, 1);
    lv_flag = 1'b0; mr_req = 1'b0;
    wait_rst(1'b0, 2000, n);
    check(n == exp_hold(hs), "R3", n, exp_hold(hs));
  endtask

  // R4, R5, R8: expiry timing, strobe and the full hold after it
  task automatic t_wd(input logic [1:0] ws, input logic [1:0] hs);
    int n;
    t_por(hs, ws);
    wait_rst(1'b1, 3000, n);
    check(n == exp_period(ws), "R4", n, exp_period(ws));
    check(wd_cause === 1'b1, "R5", wd_cause, 1);
    cyc(1);
    check(wd_cause === 1'b0, "R5", wd_cause, 0);
    wait_rst(1'b0, 2000, n);
    check(n == exp_hold(hs) - 1, "R5", n, exp_hold(hs) - 1);
    wait_rst(1'b1, 3000, n);
    check(n == exp_period(ws), "R8", n, exp_period(ws));
  endtask

  // R6: kicks restart the count
  task automatic t_kick();
    int n;
    int hits = 0;
    t_por(2'b00, 2'b10);
    for (int k = 0; k < 10; k++) begin
      cyc(20);
      wd_kick = 1'b1; cyc(1); wd_kick = 1'b0;
      hits += sys_rst;
    end
    check(hits == 0 && sys_rst === 1'b0, "R6", hits, 0);
    cyc(10);
    wd_kick = 1'b1; cyc(1); wd_kick = 1'b0;
    wait_rst(1'b1, 3000, n);
    check(n == 25, "R6", n, 25);
  endtask

  // R7: disabled watchdog never fires
  task automatic t_off();
    int hits = 0;
    t_por(2'b01, 2'b11);
    for (int k = 0; k < 3000; k++) begin cyc(1); hits += sys_rst; end
    check(hits == 0, "R7", hits, 0);
  endtask

  // R10: no tick, no progress
  task automatic t_notick();
    int n;
    int hits = 0;
    rst_n = 1'b0; hold_sel = 2'b00; wd_sel = 2'b10; ms_tick = 1'b0;
    cyc(2);
    rst_n = 1'b1;
    cyc(300);
    check(sys_rst === 1'b1, "R10", sys_rst, 1);
    ms_tick = 1'b1;
    wait_rst(1'b0, 2000, n);
    check(n == 50, "R10", n, 50);
    ms_tick = 1'b0;
    for (int k = 0; k < 300; k++) begin cyc(1); hits += sys_rst; end
    check(hits == 0, "R10", hits, 0);
    ms_tick = 1'b1;
    wait_rst(1'b1, 3000, n);
    check(n == 25, "R10", n, 25);
  endtask

  initial begin : watchdog_timer
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL timeout: actual %0d expected %0d", 150000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_por(2'b01, 2'b11);
    t_fault(1'b0, 2'b00);
    t_fault(1'b1, 2'b11);
    t_fault(1'b1, 2'b10);
    t_off();
    t_wd(2'b10, 2'b00);
    t_wd(2'b01, 2'b00);
    t_wd(2'b00, 2'b00);
    t_kick();
    t_notick();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule